// File: doc/BRIEF.md
# Parallel Configuration Port Loader

The loader feeds a byte-wide parallel configuration port of a programmable logic device from one of two sources. One source is a flash memory shared with other masters. The other is a stream of bytes pushed by the host. A host controller steers it with a short byte-oriented command stream. Through that stream it loads a flash start and stop word address and a host byte count. It then launches a pass from flash or from the host, starts a periodic scrub, or aborts.

Each byte is presented on the configuration data bus. The configuration clock pulses once for that byte only. Gaps in delivery therefore just stretch the time between clock pulses. The loader never looks inside the bytes: every device command is already part of the stream. In scrub mode the same flash region is replayed over and over. The loader waits a programmable number of idle cycles between passes, so that static configuration contents are rewritten continually.

For flash, the loader raises a request and waits until the arbiter names it as owner. It then issues one read strobe per 16-bit word and waits for data-valid. Each word becomes two configuration bytes.

Top module: `cfgld_loader`

## Requirements
- R1: Commands arrive one byte per `cmd_valid` cycle. The first byte of each command is its opcode, and any operand bytes follow least significant byte first. The opcodes are:
  - 0x01 sets the start address (3 operand bytes).
  - 0x02 sets the stop address (3 operand bytes).
  - 0x03 runs a pass from flash.
  - 0x04 sets the host byte count (2 operand bytes).
  - 0x05 runs a pass from the host.
  - 0x06 starts scrubbing (2 operand bytes of period).
  - 0x0F aborts.

  Any other opcode is ignored. An operand byte is never taken as an opcode, even when its value equals one.
- R2: A flash pass reads word addresses from start through stop inclusive, in rising order. If stop is below start, only the start word is read. Each word is emitted high byte first, then low byte.
- R3: `flash_req` is high throughout the flash reads of a pass. `flash_rd` pulses for one cycle per word, and only while `flash_owner` equals the loader's ID and `flash_busy` is low. The word is taken on `flash_dvalid`.
- R4: `cfg_clk` is high for exactly one cycle per emitted byte and is never high in two consecutive cycles. `cfg_data` holds that byte in the cycle before the pulse and during it. `cfg_clk` is high only while `cfg_sel` is high.
- R5: A host pass with count N clocks out exactly N bytes, in arrival order. A byte is taken only in a cycle where both `bus_valid` and `bus_ready` are high. With N = 0, no byte is emitted.
- R6: `busy`, `cfg_sel` and `cfg_wr` rise when a pass starts. They stay high until the cycle after the last `cfg_clk` pulse of that pass, and they are low at reset.
- R7: After a scrub command, flash passes repeat. Between the end of one pass and the start of the next, `busy` stays low for exactly period+1 cycles.
- R8: Abort is sampled at a clock edge. By the second edge after that, `busy`, `cfg_sel`, `flash_req` and `cfg_clk` are low. No later `cfg_clk` pulse occurs, and scrubbing stops.
- R9: Run and scrub commands that arrive while a pass is active, or while scrubbing is armed, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command opcode or operand byte |
| bus_valid | input | 1 | Host data byte offered |
| bus_byte | input | 8 | Host data byte |
| bus_ready | output | 1 | Loader takes a host byte this cycle |
| flash_req | output | 1 | Request for the shared flash |
| flash_owner | input | 2 | ID of the current flash owner |
| flash_busy | input | 1 | Flash is servicing an access |
| flash_rd | output | 1 | One-cycle read strobe |
| flash_addr | output | 24 | Flash word address |
| flash_dvalid | input | 1 | Read data valid |
| flash_data | input | 16 | Flash read word |
| cfg_data | output | 8 | Configuration data byte |
| cfg_clk | output | 1 | Gated configuration clock |
| cfg_wr | output | 1 | Write enable, active high |
| cfg_sel | output | 1 | Chip select, active high |
| busy | output | 1 | A pass is in progress |

## Verification
The sharpest overlap is an abort that lands in the same cycle as a byte being taken. The bench provokes it in a host pass by holding `bus_valid` high and driving the abort opcode in a cycle where `bus_ready` is high. It provokes the same overlap in a flash pass while reads and byte emission are under way. In both cases it judges that all outputs are quiet by the second edge and that no further configuration clock pulse appears, even for the byte accepted alongside the abort. It also sends an operand byte equal to the abort code in the middle of a host pass, and requires the pass to finish intact.

// File: rtl/cfgld_pkg.sv
// Shared constants for the configuration port loader.
// Assumes byte-wide configuration data and 16-bit flash words.
package cfgld_pkg;
    localparam int BYTE_W  = 8;
    localparam int FLASH_W = 16;

    localparam logic [7:0] OP_SET_START = 8'h01;
    localparam logic [7:0] OP_SET_STOP  = 8'h02;
    localparam logic [7:0] OP_RUN_FLASH = 8'h03;
    localparam logic [7:0] OP_SET_COUNT = 8'h04;
    localparam logic [7:0] OP_RUN_BUS   = 8'h05;
    localparam logic [7:0] OP_SCRUB     = 8'h06;
    localparam logic [7:0] OP_ABORT     = 8'h0F;

    typedef enum logic [2:0] {
        S_IDLE, S_FREQ, S_FWAIT, S_FHI, S_FLO, S_BRUN, S_DRAIN, S_SWAIT
    } seq_e;
endpackage

// File: rtl/cfgld_cmd.sv
// Command decoder: splits the byte stream into opcodes and little-endian
// operands, holds the operand registers and emits one-cycle registered
// pulses for run, scrub and abort. Assumes operands of at most 7 bytes.
module cfgld_cmd
    import cfgld_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] stop_addr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [PER_W-1:0]  period,
    output logic              go_flash,
    output logic              go_bus,
    output logic              go_scrub,
    output logic              abort_p
);
    localparam int A_B  = (ADDR_W + 7) / 8;
    localparam int C_B  = (CNT_W + 7) / 8;
    localparam int P_B  = (PER_W + 7) / 8;
    localparam int AC_B = (A_B > C_B) ? A_B : C_B;
    localparam int MAXB = (AC_B > P_B) ? AC_B : P_B;
    localparam int SH_W = 8 * MAXB;

    logic [2:0]      need;
    logic [7:0]      opc;
    logic [SH_W-1:0] sh, full, val;

    assign full = {cmd_byte, sh[SH_W-1:8]};

    // Align the assembled operand to bit 0 according to its byte length.
    always_comb begin
        case (opc)
            OP_SET_START, OP_SET_STOP: val = full >> (8 * (MAXB - A_B));
            OP_SET_COUNT:              val = full >> (8 * (MAXB - C_B));
            default:                   val = full >> (8 * (MAXB - P_B));
        endcase
    end

    // Track the opcode and operand bytes still expected; update registers and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need <= '0; opc <= '0; sh <= '0;
            start_addr <= '0; stop_addr <= '0; byte_cnt <= '0; period <= '0;
            go_flash <= 1'b0; go_bus <= 1'b0; go_scrub <= 1'b0; abort_p <= 1'b0;
        end else begin
            go_flash <= 1'b0; go_bus <= 1'b0; go_scrub <= 1'b0; abort_p <= 1'b0;
            if (cmd_valid) begin
                if (need == 3'd0) begin
                    opc <= cmd_byte;
                    case (cmd_byte)
                        OP_SET_START, OP_SET_STOP: need <= 3'(A_B);
                        OP_SET_COUNT:              need <= 3'(C_B);
                        OP_SCRUB:                  need <= 3'(P_B);
                        OP_RUN_FLASH:              go_flash <= 1'b1;
                        OP_RUN_BUS:                go_bus <= 1'b1;
                        OP_ABORT:                  abort_p <= 1'b1;
                        default: ;
                    endcase
                end else begin
                    sh   <= full;
                    need <= need - 3'd1;
                    if (need == 3'd1) begin
                        case (opc)
                            OP_SET_START: start_addr <= val[ADDR_W-1:0];
                            OP_SET_STOP:  stop_addr  <= val[ADDR_W-1:0];
                            OP_SET_COUNT: byte_cnt   <= val[CNT_W-1:0];
                            OP_SCRUB: begin
                                period   <= val[PER_W-1:0];
                                go_scrub <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // R1: an operand byte never produces a command pulse.
    a_r1_operand_not_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && need != 3'd0) |=> !(go_flash || go_bus || abort_p));
endmodule

// File: rtl/cfgld_emit.sv
// Byte emitter: latches a byte, then raises the configuration clock for one
// cycle while the byte is held. Accepts a new byte every other cycle at most.
// Assumes the caller pushes only while ready is high; kill wins over push.
module cfgld_emit
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_byte,
    output logic              ready,
    output logic              idle,
    output logic [BYTE_W-1:0] cfg_data,
    output logic              cfg_clk
);
    logic setup;

    assign ready = !setup;
    assign idle  = !setup && !cfg_clk;

    // Set-up cycle with data on the bus, then one clock-high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup <= 1'b0; cfg_clk <= 1'b0; cfg_data <= '0;
        end else if (kill) begin
            setup <= 1'b0; cfg_clk <= 1'b0;
        end else begin
            cfg_clk <= setup;
            setup   <= push;
            if (push) cfg_data <= push_byte;
        end
    end

    // R4: single-cycle pulses with data held across them.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |=> !cfg_clk);
    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_data));
    a_r4_push_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ready);
    // R8: a kill leaves no clock pulse behind.
    a_r8_kill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!cfg_clk && ready));
endmodule

// File: rtl/cfgld_loader.sv
// Configuration port loader top: sequences flash passes, host passes and
// periodic scrubs; gains the shared flash through a request/owner handshake.
// Assumes the flash answers each read strobe with one data-valid pulse.
module cfgld_loader
    import cfgld_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int PER_W  = 16,
    parameter int OWN_W  = 2,
    parameter int OWN_ID = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_byte,
    input  logic               bus_valid,
    input  logic [7:0]         bus_byte,
    output logic               bus_ready,
    output logic               flash_req,
    input  logic [OWN_W-1:0]   flash_owner,
    input  logic               flash_busy,
    output logic               flash_rd,
    output logic [ADDR_W-1:0]  flash_addr,
    input  logic               flash_dvalid,
    input  logic [FLASH_W-1:0] flash_data,
    output logic [7:0]         cfg_data,
    output logic               cfg_clk,
    output logic               cfg_wr,
    output logic               cfg_sel,
    output logic               busy
);
    logic [ADDR_W-1:0]  start_addr, stop_addr, addr;
    logic [CNT_W-1:0]   byte_cnt, remain;
    logic [PER_W-1:0]   period, timer;
    logic               go_flash, go_bus, go_scrub, abort_p;
    logic               emit_ready, emit_idle, push, scrub_on;
    logic [7:0]         pbyte;
    logic [FLASH_W-1:0] word;
    seq_e               st;

    cfgld_cmd #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PER_W(PER_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .start_addr(start_addr), .stop_addr(stop_addr), .byte_cnt(byte_cnt),
        .period(period), .go_flash(go_flash), .go_bus(go_bus),
        .go_scrub(go_scrub), .abort_p(abort_p));

    cfgld_emit u_emit (
        .clk(clk), .rst_n(rst_n), .kill(abort_p), .push(push), .push_byte(pbyte),
        .ready(emit_ready), .idle(emit_idle), .cfg_data(cfg_data), .cfg_clk(cfg_clk));

    assign busy       = !(st == S_IDLE || st == S_SWAIT);
    assign cfg_sel    = busy;
    assign cfg_wr     = busy;
    assign flash_req  = st inside {S_FREQ, S_FWAIT, S_FHI, S_FLO};
    assign flash_rd   = (st == S_FREQ) && (flash_owner == OWN_W'(OWN_ID)) && !flash_busy;
    assign flash_addr = addr;
    assign bus_ready  = (st == S_BRUN) && emit_ready && (remain != '0);

    // Pick the byte offered to the emitter from the active source.
    always_comb begin
        push  = 1'b0;
        pbyte = bus_byte;
        case (st)
            S_FHI:  begin push = emit_ready; pbyte = word[FLASH_W-1:8]; end
            S_FLO:  begin push = emit_ready; pbyte = word[7:0]; end
            S_BRUN: push = bus_valid && bus_ready;
            default: ;
        endcase
    end

    // Pass sequencer: flash word loop, host byte loop, drain and scrub wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; addr <= '0; remain <= '0; timer <= '0;
            word <= '0; scrub_on <= 1'b0;
        end else if (abort_p) begin
            st <= S_IDLE; scrub_on <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (go_flash) begin
                        addr <= start_addr; st <= S_FREQ;
                    end else if (go_scrub) begin
                        scrub_on <= 1'b1; addr <= start_addr; st <= S_FREQ;
                    end else if (go_bus) begin
                        remain <= byte_cnt; st <= S_BRUN;
                    end
                end
                S_FREQ:  if (flash_rd) st <= S_FWAIT;
                S_FWAIT: if (flash_dvalid) begin word <= flash_data; st <= S_FHI; end
                S_FHI:   if (emit_ready) st <= S_FLO;
                S_FLO: begin
                    if (emit_ready) begin
                        if (addr >= stop_addr) st <= S_DRAIN;
                        else begin addr <= addr + 1'b1; st <= S_FREQ; end
                    end
                end
                S_BRUN: begin
                    if (remain == '0) st <= S_DRAIN;
                    else if (push) remain <= remain - 1'b1;
                end
                S_DRAIN: begin
                    if (emit_idle) begin
                        if (scrub_on) begin st <= S_SWAIT; timer <= period; end
                        else st <= S_IDLE;
                    end
                end
                S_SWAIT: begin
                    if (timer == '0) begin addr <= start_addr; st <= S_FREQ; end
                    else timer <= timer - 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R3: one strobe per word, always under a held request.
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |=> !flash_rd);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |-> flash_req);
    // R4: the configuration clock runs only under chip select.
    a_r4_clk_selected: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> cfg_sel);
    // R6: a pass ends only after its last pulse.
    a_r6_end_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cfg_clk);
    // R8: abort clears the pass and releases the flash on the next edge.
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> (!busy && !flash_req));
endmodule

// File: tb/cfgld_loader_test.sv
module cfgld_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        bus_valid = 1'b0;
    logic [7:0]  bus_byte = '0;
    logic        bus_ready, flash_req, flash_rd, cfg_clk, cfg_wr, cfg_sel, busy;
    logic [1:0]  flash_owner = 2'd2;
    logic        flash_busy = 1'b0;
    logic [23:0] flash_addr;
    logic        flash_dvalid = 1'b0;
    logic [15:0] flash_data = '0;
    logic [7:0]  cfg_data;

    int n_tests = 0, n_fail = 0;
    int ngot = 0, nexp = 0, bad_rd = 0;
    logic [7:0] got [0:511];
    logic [7:0] expb [0:511];
    logic [23:0] rd_addr = '0;
    int lat = 0, gdel = 0;

    always #5 clk = ~clk;

    cfgld_loader uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .bus_valid(bus_valid), .bus_byte(bus_byte), .bus_ready(bus_ready),
        .flash_req(flash_req), .flash_owner(flash_owner), .flash_busy(flash_busy),
        .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_dvalid(flash_dvalid),
        .flash_data(flash_data), .cfg_data(cfg_data), .cfg_clk(cfg_clk),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .busy(busy));

    function automatic logic [15:0] fword(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ a[7:0] ^ 8'hC3};
    endfunction

    // Flash and arbiter model: grant after a random delay, random read latency.
    always @(posedge clk) begin
        flash_dvalid <= 1'b0;
        if (!flash_req) begin
            flash_owner <= 2'd2;
            gdel <= int'($urandom % 5);
        end else if (gdel != 0) gdel <= gdel - 1;
        else flash_owner <= 2'd1;
        if (flash_rd) begin
            rd_addr <= flash_addr; lat <= 1 + int'($urandom % 4); flash_busy <= 1'b1;
        end else if (flash_busy) begin
            if (lat == 1) begin
                flash_busy <= 1'b0; flash_dvalid <= 1'b1; flash_data <= fword(rd_addr);
            end
            lat <= lat - 1;
        end
    end

    // Collect every clocked byte and watch the read handshake rules.
    always @(negedge clk) begin
        if (rst_n && cfg_clk) begin
            if (ngot < 512) got[ngot] = cfg_data;
            ngot = ngot + 1;
        end
        if (rst_n && flash_rd && (flash_owner != 2'd1 || flash_busy)) bad_rd = bad_rd + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] op, input logic [23:0] a);
        send(op); send(a[7:0]); send(a[15:8]); send(a[23:16]);
    endtask

    task automatic send16(input logic [7:0] op, input logic [15:0] v);
        send(op); send(v[7:0]); send(v[15:8]);
    endtask

    task automatic wait_busy(input logic lvl);
        for (int i = 0; i < 20000 && busy !== lvl; i++) @(negedge clk);
    endtask

    task automatic exp_flash(input logic [23:0] s, input logic [23:0] t);
        logic [23:0] a = s;
        while (1) begin
            expb[nexp] = fword(a)[15:8]; expb[nexp+1] = fword(a)[7:0];
            nexp += 2;
            if (a >= t) break;
            a = a + 1;
        end
    endtask

    task automatic cmp(input string tag, input string what);
        int bad = -1;
        chk(ngot == nexp, tag, {what, " byte count"}, ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++)
            if (bad < 0 && got[i] !== expb[i]) bad = i;
        if (bad >= 0) chk(1'b0, tag, {what, " byte value"}, got[bad], expb[bad]);
        else chk(1'b1, tag, what, 0, 0);
    endtask

    task automatic flash_pass(input logic [23:0] s, input logic [23:0] t, input string tag);
        send_addr(8'h01, s); send_addr(8'h02, t);
        ngot = 0; nexp = 0; exp_flash(s, t);
        send(8'h03);
        wait_busy(1'b1); wait_busy(1'b0);
        cmp(tag, "flash pass");
        chk(!flash_req, "R3", "request released", flash_req, 0);
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'($urandom);
            while (bus_ready !== 1'b1) @(negedge clk);
            bus_valid = 1'b1; bus_byte = b;
            expb[nexp] = b; nexp++;
            @(negedge clk); bus_valid = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
        end
    endtask

    task automatic check_quiet(input string what);
        int c;
        @(negedge clk);
        chk(!busy && !cfg_sel && !flash_req && !cfg_clk, "R8", what,
            {busy, cfg_sel, flash_req, cfg_clk}, 0);
        c = ngot;
        repeat (40) @(negedge clk);
        chk(ngot == c, "R8", {what, " no later pulse"}, ngot, c);
        chk(!busy && !flash_req, "R8", {what, " stays idle"}, {busy, flash_req}, 0);
    endtask

    initial begin
        int gap;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, cfg_sel, cfg_wr, cfg_clk, flash_req, bus_ready} == 6'b0, "R6",
            "reset outputs", {busy, cfg_sel, cfg_wr, cfg_clk, flash_req, bus_ready}, 0);

        // R2 directed: ascending region, single word, stop below start
        flash_pass(24'h000010, 24'h000013, "R2");
        flash_pass(24'h123456, 24'h123456, "R2");
        flash_pass(24'h000200, 24'h0001F0, "R2");

        // R5 directed: zero count
        send16(8'h04, 16'd0); ngot = 0; send(8'h05);
        repeat (10) @(negedge clk);
        chk(ngot == 0 && !busy, "R5", "zero count pass", ngot, 0);

        // Random flash and host passes
        for (int k = 0; k < 6; k++) begin
            logic [23:0] s = 24'($urandom) & 24'hFFFF00;
            flash_pass(s, s + 24'($urandom % 5), "R2");
        end
        for (int k = 0; k < 6; k++) begin
            int n = 1 + int'($urandom % 12);
            send16(8'h04, 16'(n)); ngot = 0; nexp = 0; send(8'h05);
            feed(n);
            wait_busy(1'b0);
            cmp("R5", "host pass");
        end

        // R6: select and write enable track the pass
        send16(8'h04, 16'd2); ngot = 0; nexp = 0; send(8'h05);
        wait_busy(1'b1);
        chk(cfg_sel && cfg_wr, "R6", "select during pass", {cfg_sel, cfg_wr}, 3);
        feed(2); wait_busy(1'b0);
        chk(!cfg_sel && !cfg_wr, "R6", "select after pass", {cfg_sel, cfg_wr}, 0);

        // R1: unknown opcode ignored; abort-valued operand does not abort
        ngot = 0; send(8'h77); send(8'h00);
        repeat (10) @(negedge clk);
        chk(!busy && ngot == 0, "R1", "unknown opcode", {busy, 8'(ngot)}, 0);
        send16(8'h04, 16'd4); ngot = 0; nexp = 0; send(8'h05);
        feed(2);
        send_addr(8'h01, 24'h000F0F);
        feed(2);
        wait_busy(1'b0);
        cmp("R1", "operand equal to abort code");

        // R9: run command during an active pass is ignored
        send_addr(8'h01, 24'h000400); send_addr(8'h02, 24'h000407);
        send16(8'h04, 16'd3);
        ngot = 0; nexp = 0; exp_flash(24'h000400, 24'h000407);
        send(8'h03); wait_busy(1'b1);
        send(8'h05);
        wait_busy(1'b0);
        repeat (10) @(negedge clk);
        chk(!busy && !bus_ready, "R9", "run ignored while busy", {busy, bus_ready}, 0);
        cmp("R9", "pass unchanged");

        // R7: scrub repeats with a gap of period+1 idle cycles
        send_addr(8'h01, 24'h000020); send_addr(8'h02, 24'h000022);
        ngot = 0; nexp = 0;
        exp_flash(24'h000020, 24'h000022); exp_flash(24'h000020, 24'h000022);
        send16(8'h06, 16'd7);
        wait_busy(1'b1); wait_busy(1'b0);
        gap = 0;
        while (busy == 1'b0 && gap < 1000) begin gap++; @(negedge clk); end
        chk(gap == 8, "R7", "scrub gap", gap, 8);
        send(8'h03);  // R9: ignored while scrub armed
        wait_busy(1'b0);
        cmp("R7", "two scrub passes");
        send(8'h0F);
        check_quiet("scrub stopped by abort");

        // R8: abort in the middle of a flash pass
        send_addr(8'h01, 24'h000100); send_addr(8'h02, 24'h00011F);
        ngot = 0; send(8'h03);
        for (int i = 0; i < 5000 && ngot < 6; i++) @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h0F;
        @(negedge clk); cmd_valid = 1'b0;
        check_quiet("abort during flash pass");

        // R8: abort in the same cycle a host byte is taken
        send16(8'h04, 16'd40); ngot = 0; send(8'h05);
        bus_valid = 1'b1; bus_byte = 8'h3C;
        for (int i = 0; i < 5000 && ngot < 5; i++) @(negedge clk);
        while (bus_ready !== 1'b1) @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h0F;
        @(negedge clk); cmd_valid = 1'b0;
        check_quiet("abort with host byte collision");
        bus_valid = 1'b0;

        // Recovery after abort
        flash_pass(24'h000300, 24'h000301, "R2");

        chk(bad_rd == 0, "R3", "reads only when owned and not busy", bad_rd, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule